// File: doc/BRIEF.md
# Copy Engine Channel Controller

This block is the control and state logic for one channel of a memory engine that can XOR blocks together, copy them, compute a CRC32 over them, or fill a region with a 64-bit pattern. Software programs a small register set through a simple write port. It sets the operation mode and burst limits, a descriptor pointer, a destination pointer, a block length and a two-word fill pattern. It then drives the channel with one-shot command bits: start, stop, pause and restart. The controller does not move data. It decides whether each command is allowed in the current state and whether the parameters are valid for the selected mode. On acceptance it emits a single-cycle launch pulse carrying the mode, pointer, length and pattern to an external datapath.

The channel is always in one of three states: idle, active or paused. Pause and restart produce hold and resume pulses toward the datapath. An accepted stop produces an abort pulse. A done pulse from the datapath ends an active job.

Rejected commands never change the state. A start issued while a job is running raises a sticky busy flag. Any other illegal command or bad parameter raises a sticky error flag. Software clears either flag by writing a 1 to its bit.

Top module: `copy_chan_ctrl`

Register word addresses: 0 config, 1 descriptor pointer, 2 destination pointer, 3 block length, 4 pattern low word, 5 pattern high word, 6 command/status. Config fields: mode [1:0] (0 XOR, 1 DMA copy, 2 CRC32, 3 fill), source burst [6:4], destination burst [10:8], access protect [12], mode-update enable [DW-1] (write only). Command/status fields: start [0], stop [1], pause [2], restart [3], status [5:4] (00 idle, 01 active, 10 paused), error [8], busy [9].

## Requirements
- R1: After reset the status reads 00 (idle), the error and busy flags read 0, the mode reads 0 (XOR), both burst fields read 4, access protect reads 1, and no launch, abort, hold or resume pulse is driven.
- R2: A start written from idle with valid parameters makes the status read 01 two cycles after the write. In that cycle launch is high for exactly one cycle, with launch_mode equal to the configured mode and launch_ptr equal to the descriptor pointer.
- R3: In XOR mode (0) a start is refused when the descriptor pointer has any of bits [5:0] set or is zero. The refusal sets the error flag, leaves the status idle and emits no launch.
- R4: In DMA copy (1) and CRC32 (2) modes a start needs descriptor pointer bits [4:0] zero and a nonzero pointer. Otherwise it is refused and sets the error flag.
- R5: In fill mode (3) a start needs the block length within [BSZ_MIN, BSZ_MAX] (defaults 128 and 0x00FF_FFFF). The launch carries the destination pointer as launch_ptr, the length as launch_len, and {high word, low word} as launch_fill.
- R6: A start while active sets the busy flag (bit 9), does not set the error flag, emits no launch and leaves the status at 01.
- R7: Pause from active gives status 10 and one hold pulse. Restart from paused gives status 01 and one resume pulse. Start from paused relaunches with a launch pulse.
- R8: Stop from active gives status 00 and one abort pulse. Stop while idle is accepted silently: no abort, no error flag, status stays 00.
- R9: Pause or restart from a state that does not allow it, stop while paused, and any write with more than one command bit set all set the error flag and leave the status unchanged.
- R10: Writing 1 to bit 8 or bit 9 of the command/status word clears that flag. Writing 0 there leaves it unchanged.
- R11: A config write with the mode-update bit clear updates the burst and access-protect fields but keeps the mode. With the bit set, the mode is loaded too.
- R12: A done pulse while active returns the status to 00. A done pulse while paused or idle has no effect.
- R13: A command bit written as 1 reads back as 1 for exactly the cycle after the write and as 0 after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for writes |
| wr_data | input | DW | Write data |
| rd_addr | input | 3 | Register word address for reads |
| rd_data | output | DW | Read data (combinational) |
| done_i | input | 1 | Job-complete pulse from the datapath |
| launch_o | output | 1 | One-cycle job start pulse |
| launch_mode_o | output | 2 | Mode of the launched job |
| launch_ptr_o | output | DW | Descriptor pointer, or destination pointer in fill mode |
| launch_len_o | output | DW | Block length of the launched job |
| launch_fill_o | output | 2*DW | Fill pattern of the launched job |
| abort_o | output | 1 | One-cycle abort pulse on an accepted stop |
| hold_o | output | 1 | One-cycle hold pulse on an accepted pause |
| resume_o | output | 1 | One-cycle resume pulse on an accepted restart |
| src_burst_o | output | BW | Source burst limit |
| dst_burst_o | output | BW | Destination burst limit |
| acc_prot_o | output | 1 | Access-protect enable |

## Verification
The bench steps through every command from every state. A design with a loose legality table would accept pause from idle or stop from paused, and would move the state on a refused command. A design that flagged a silent stop from idle as an error would also be caught. The alignment tests use pointers with only bit 5 set and with bit 3 set, so that swapping the XOR and copy/CRC masks, or forgetting the nonzero rule, shows up as a wrong launch or a missing error. The fill tests probe the length one below the minimum, one above the maximum and exactly at the maximum, to catch off-by-one range checks. Separate scenarios show that a plain config write keeps the mode, that done is ignored while paused, and that flags clear only on a written 1.

// File: rtl/cce_pkg.sv
package cce_pkg;

  typedef enum logic [1:0] {
    MODE_XOR  = 2'd0,
    MODE_DMA  = 2'd1,
    MODE_CRC  = 2'd2,
    MODE_FILL = 2'd3
  } op_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACTIVE = 2'b01,
    ST_PAUSED = 2'b10
  } chan_st_e;

  localparam int unsigned AW_REG = 3;

  localparam logic [AW_REG-1:0] RA_CFG  = 3'd0;
  localparam logic [AW_REG-1:0] RA_NDP  = 3'd1;
  localparam logic [AW_REG-1:0] RA_DST  = 3'd2;
  localparam logic [AW_REG-1:0] RA_BSZ  = 3'd3;
  localparam logic [AW_REG-1:0] RA_FLO  = 3'd4;
  localparam logic [AW_REG-1:0] RA_FHI  = 3'd5;
  localparam logic [AW_REG-1:0] RA_ACT  = 3'd6;

  localparam int unsigned NCMD     = 4;
  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_STOP  = 1;
  localparam int unsigned CB_PAUSE = 2;
  localparam int unsigned CB_RSTRT = 3;

  localparam int unsigned FB_ST    = 4;
  localparam int unsigned FB_ERR   = 8;
  localparam int unsigned FB_BUSY  = 9;

  localparam int unsigned CF_SRCB  = 4;
  localparam int unsigned CF_DSTB  = 8;
  localparam int unsigned CF_PROT  = 12;

  // Pointer check: low bits must be zero (count depends on mode), pointer nonzero.
  function automatic logic ptr_aligned(op_mode_e m, logic [63:0] p,
                                       int unsigned xor_lsb, int unsigned cpy_lsb);
    logic [63:0] msk;
    int unsigned nb;
    nb  = (m == MODE_XOR) ? xor_lsb : cpy_lsb;
    msk = (64'd1 << nb) - 64'd1;
    return ((p & msk) == 64'd0) && (p != 64'd0);
  endfunction

  function automatic logic len_in_range(logic [63:0] len, logic [63:0] lo,
                                        logic [63:0] hi);
    return (len >= lo) && (len <= hi);
  endfunction

endpackage

// File: rtl/cce_regs.sv
module cce_regs
  import cce_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW_REG-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW_REG-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  chan_st_e          status_i,
  input  logic              err_i,
  input  logic              busy_i,
  output op_mode_e          mode_o,
  output logic [BW-1:0]     src_burst_o,
  output logic [BW-1:0]     dst_burst_o,
  output logic              prot_o,
  output logic [DW-1:0]     ndp_o,
  output logic [DW-1:0]     dst_o,
  output logic [DW-1:0]     bsz_o,
  output logic [2*DW-1:0]   fill_o,
  output logic [NCMD-1:0]   cmd_o,
  output logic              clr_err_o,
  output logic              clr_busy_o
);

  localparam int unsigned MODE_SET = DW - 1;
  localparam logic [BW-1:0] BURST_RST = BW'(4);

  op_mode_e        mode_q;
  logic [BW-1:0]   srcb_q, dstb_q;
  logic            prot_q;
  logic [DW-1:0]   ndp_q, dst_q, bsz_q, flo_q, fhi_q;
  logic [NCMD-1:0] cmd_q;

  logic wr_cfg, wr_act;
  assign wr_cfg = wr_en && (wr_addr == RA_CFG);
  assign wr_act = wr_en && (wr_addr == RA_ACT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_XOR;
      srcb_q <= BURST_RST;
      dstb_q <= BURST_RST;
      prot_q <= 1'b1;
    end else if (wr_cfg) begin
      if (wr_data[MODE_SET]) mode_q <= op_mode_e'(wr_data[1:0]);
      srcb_q <= wr_data[CF_SRCB +: BW];
      dstb_q <= wr_data[CF_DSTB +: BW];
      prot_q <= wr_data[CF_PROT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ndp_q <= '0;
      dst_q <= '0;
      bsz_q <= '0;
      flo_q <= '0;
      fhi_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_NDP:  ndp_q <= wr_data;
        RA_DST:  dst_q <= wr_data;
        RA_BSZ:  bsz_q <= wr_data;
        RA_FLO:  flo_q <= wr_data;
        RA_FHI:  fhi_q <= wr_data;
        default: ;
      endcase
    end
  end

  // Command bits live for exactly one cycle after the write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= wr_act ? wr_data[NCMD-1:0] : '0;
  end

  assign clr_err_o  = wr_act && wr_data[FB_ERR];
  assign clr_busy_o = wr_act && wr_data[FB_BUSY];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CFG: begin
        rd_data[1:0]           = mode_q;
        rd_data[CF_SRCB +: BW] = srcb_q;
        rd_data[CF_DSTB +: BW] = dstb_q;
        rd_data[CF_PROT]       = prot_q;
      end
      RA_NDP: rd_data = ndp_q;
      RA_DST: rd_data = dst_q;
      RA_BSZ: rd_data = bsz_q;
      RA_FLO: rd_data = flo_q;
      RA_FHI: rd_data = fhi_q;
      RA_ACT: begin
        rd_data[NCMD-1:0]    = cmd_q;
        rd_data[FB_ST +: 2]  = status_i;
        rd_data[FB_ERR]      = err_i;
        rd_data[FB_BUSY]     = busy_i;
      end
      default: rd_data = '0;
    endcase
  end

  assign mode_o      = mode_q;
  assign src_burst_o = srcb_q;
  assign dst_burst_o = dstb_q;
  assign prot_o      = prot_q;
  assign ndp_o       = ndp_q;
  assign dst_o       = dst_q;
  assign bsz_o       = bsz_q;
  assign fill_o      = {fhi_q, flo_q};
  assign cmd_o       = cmd_q;

  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !wr_data[MODE_SET]) |=> $stable(mode_q)); // R11

  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q != '0) && !wr_act) |=> (cmd_q == '0)); // R13

endmodule

// File: rtl/cce_judge.sv
module cce_judge
  import cce_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter logic [63:0] BSZ_MIN   = 64'd128,
  parameter logic [63:0] BSZ_MAX   = 64'h00FF_FFFF,
  parameter int unsigned XOR_LSB   = 6,
  parameter int unsigned CPY_LSB   = 5
) (
  input  chan_st_e        state_i,
  input  logic [NCMD-1:0] cmd_i,
  input  op_mode_e        mode_i,
  input  logic [DW-1:0]   ndp_i,
  input  logic [DW-1:0]   bsz_i,
  output logic            acc_start_o,
  output logic            acc_stop_o,
  output logic            acc_pause_o,
  output logic            acc_rstrt_o,
  output logic            stop_noop_o,
  output logic            rej_illegal_o,
  output logic            rej_param_o,
  output logic            rej_busy_o
);

  logic params_ok, single, multi;

  always_comb begin
    if (mode_i == MODE_FILL) params_ok = len_in_range(64'(bsz_i), BSZ_MIN, BSZ_MAX);
    else                     params_ok = ptr_aligned(mode_i, 64'(ndp_i), XOR_LSB, CPY_LSB);
  end

  assign single = ($countones(cmd_i) == 1);
  assign multi  = ($countones(cmd_i) > 1);

  always_comb begin
    acc_start_o   = 1'b0;
    acc_stop_o    = 1'b0;
    acc_pause_o   = 1'b0;
    acc_rstrt_o   = 1'b0;
    stop_noop_o   = 1'b0;
    rej_illegal_o = multi;
    rej_param_o   = 1'b0;
    rej_busy_o    = 1'b0;
    if (single) begin
      if (cmd_i[CB_START]) begin
        if (state_i == ST_ACTIVE) rej_busy_o  = 1'b1;
        else if (!params_ok)      rej_param_o = 1'b1;
        else                      acc_start_o = 1'b1;
      end
      if (cmd_i[CB_STOP]) begin
        case (state_i)
          ST_ACTIVE: acc_stop_o    = 1'b1;
          ST_IDLE:   stop_noop_o   = 1'b1;
          default:   rej_illegal_o = 1'b1;
        endcase
      end
      if (cmd_i[CB_PAUSE]) begin
        if (state_i == ST_ACTIVE) acc_pause_o   = 1'b1;
        else                      rej_illegal_o = 1'b1;
      end
      if (cmd_i[CB_RSTRT]) begin
        if (state_i == ST_PAUSED) acc_rstrt_o   = 1'b1;
        else                      rej_illegal_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cce_fsm.sv
module cce_fsm
  import cce_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter logic [63:0] BSZ_MIN = 64'd128,
  parameter logic [63:0] BSZ_MAX = 64'h00FF_FFFF,
  parameter int unsigned XOR_LSB = 6,
  parameter int unsigned CPY_LSB = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_start_i,
  input  logic            acc_stop_i,
  input  logic            acc_pause_i,
  input  logic            acc_rstrt_i,
  input  logic            stop_noop_i,
  input  logic            rej_illegal_i,
  input  logic            rej_param_i,
  input  logic            rej_busy_i,
  input  logic            clr_err_i,
  input  logic            clr_busy_i,
  input  logic            done_i,
  input  op_mode_e        mode_i,
  input  logic [DW-1:0]   ndp_i,
  input  logic [DW-1:0]   dst_i,
  input  logic [DW-1:0]   bsz_i,
  input  logic [2*DW-1:0] fill_i,
  output chan_st_e        state_o,
  output logic            err_o,
  output logic            busy_o,
  output logic            launch_o,
  output op_mode_e        launch_mode_o,
  output logic [DW-1:0]   launch_ptr_o,
  output logic [DW-1:0]   launch_len_o,
  output logic [2*DW-1:0] launch_fill_o,
  output logic            abort_o,
  output logic            hold_o,
  output logic            resume_o
);

  chan_st_e state_q, state_d;
  logic     err_q, busy_q;
  logic     launch_q, abort_q, hold_q, resume_q;
  op_mode_e lmode_q;
  logic [DW-1:0]   lptr_q, llen_q;
  logic [2*DW-1:0] lfill_q;
  logic     done_evt;

  assign done_evt = done_i && (state_q == ST_ACTIVE) && !acc_pause_i && !acc_stop_i;

  always_comb begin
    state_d = state_q;
    if (acc_start_i || acc_rstrt_i) state_d = ST_ACTIVE;
    else if (acc_stop_i)            state_d = ST_IDLE;
    else if (acc_pause_i)           state_d = ST_PAUSED;
    else if (done_evt)              state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      err_q    <= 1'b0;
      busy_q   <= 1'b0;
      launch_q <= 1'b0;
      abort_q  <= 1'b0;
      hold_q   <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      err_q    <= (err_q & ~clr_err_i) | rej_illegal_i | rej_param_i;
      busy_q   <= (busy_q & ~clr_busy_i) | rej_busy_i;
      launch_q <= acc_start_i;
      abort_q  <= acc_stop_i;
      hold_q   <= acc_pause_i;
      resume_q <= acc_rstrt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lmode_q <= MODE_XOR;
      lptr_q  <= '0;
      llen_q  <= '0;
      lfill_q <= '0;
    end else if (acc_start_i) begin
      lmode_q <= mode_i;
      lptr_q  <= (mode_i == MODE_FILL) ? dst_i : ndp_i;
      llen_q  <= bsz_i;
      lfill_q <= fill_i;
    end
  end

  assign state_o       = state_q;
  assign err_o         = err_q;
  assign busy_o        = busy_q;
  assign launch_o      = launch_q;
  assign launch_mode_o = lmode_q;
  assign launch_ptr_o  = lptr_q;
  assign launch_len_o  = llen_q;
  assign launch_fill_o = lfill_q;
  assign abort_o       = abort_q;
  assign hold_o        = hold_q;
  assign resume_o      = resume_q;

  AST_LAUNCH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |-> (state_q == ST_ACTIVE)); // R2

  AST_LAUNCH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |-> ((lmode_q == MODE_FILL) ? len_in_range(64'(llen_q), BSZ_MIN, BSZ_MAX)
                                         : ptr_aligned(lmode_q, 64'(lptr_q), XOR_LSB, CPY_LSB))); // R3

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch_q, abort_q, hold_q, resume_q})); // R7

  AST_PAUSE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PAUSED) && ($past(state_q) != ST_PAUSED)) |-> ($past(state_q) == ST_ACTIVE)); // R7

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rej_illegal_i || rej_param_i || rej_busy_i) && !done_i) |=> $stable(state_q)); // R9

  AST_IDLE_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stop_noop_i |=> ((state_q == ST_IDLE) && !abort_q)); // R8

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (state_q == ST_IDLE)); // R12

endmodule

// File: rtl/copy_chan_ctrl.sv
module copy_chan_ctrl
  import cce_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned BW      = 3,
  parameter logic [63:0] BSZ_MIN = 64'd128,
  parameter logic [63:0] BSZ_MAX = 64'h00FF_FFFF,
  parameter int unsigned XOR_LSB = 6,
  parameter int unsigned CPY_LSB = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [2:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic            done_i,
  output logic            launch_o,
  output logic [1:0]      launch_mode_o,
  output logic [DW-1:0]   launch_ptr_o,
  output logic [DW-1:0]   launch_len_o,
  output logic [2*DW-1:0] launch_fill_o,
  output logic            abort_o,
  output logic            hold_o,
  output logic            resume_o,
  output logic [BW-1:0]   src_burst_o,
  output logic [BW-1:0]   dst_burst_o,
  output logic            acc_prot_o
);

  chan_st_e        state;
  op_mode_e        mode, lmode;
  logic            err, busy, clr_err, clr_busy;
  logic [DW-1:0]   ndp, dst, bsz;
  logic [2*DW-1:0] fill;
  logic [NCMD-1:0] cmd;
  logic acc_start, acc_stop, acc_pause, acc_rstrt, stop_noop;
  logic rej_illegal, rej_param, rej_busy;

  cce_regs #(.DW(DW), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .status_i(state), .err_i(err), .busy_i(busy),
    .mode_o(mode), .src_burst_o(src_burst_o), .dst_burst_o(dst_burst_o), .prot_o(acc_prot_o),
    .ndp_o(ndp), .dst_o(dst), .bsz_o(bsz), .fill_o(fill), .cmd_o(cmd),
    .clr_err_o(clr_err), .clr_busy_o(clr_busy)
  );

  cce_judge #(.DW(DW), .BSZ_MIN(BSZ_MIN), .BSZ_MAX(BSZ_MAX),
              .XOR_LSB(XOR_LSB), .CPY_LSB(CPY_LSB)) u_judge (
    .state_i(state), .cmd_i(cmd), .mode_i(mode), .ndp_i(ndp), .bsz_i(bsz),
    .acc_start_o(acc_start), .acc_stop_o(acc_stop), .acc_pause_o(acc_pause),
    .acc_rstrt_o(acc_rstrt), .stop_noop_o(stop_noop), .rej_illegal_o(rej_illegal),
    .rej_param_o(rej_param), .rej_busy_o(rej_busy)
  );

  cce_fsm #(.DW(DW), .BSZ_MIN(BSZ_MIN), .BSZ_MAX(BSZ_MAX),
            .XOR_LSB(XOR_LSB), .CPY_LSB(CPY_LSB)) u_fsm (
    .clk(clk), .rst_n(rst_n), .acc_start_i(acc_start), .acc_stop_i(acc_stop),
    .acc_pause_i(acc_pause), .acc_rstrt_i(acc_rstrt), .stop_noop_i(stop_noop),
    .rej_illegal_i(rej_illegal), .rej_param_i(rej_param), .rej_busy_i(rej_busy),
    .clr_err_i(clr_err), .clr_busy_i(clr_busy), .done_i(done_i), .mode_i(mode),
    .ndp_i(ndp), .dst_i(dst), .bsz_i(bsz), .fill_i(fill), .state_o(state),
    .err_o(err), .busy_o(busy), .launch_o(launch_o), .launch_mode_o(lmode),
    .launch_ptr_o(launch_ptr_o), .launch_len_o(launch_len_o),
    .launch_fill_o(launch_fill_o), .abort_o(abort_o), .hold_o(hold_o), .resume_o(resume_o)
  );

  assign launch_mode_o = lmode;

endmodule

// File: tb/copy_chan_ctrl_tb.sv
module copy_chan_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] A_CFG = 3'd0, A_NDP = 3'd1, A_DST = 3'd2, A_BSZ = 3'd3,
                         A_FLO = 3'd4, A_FHI = 3'd5, A_ACT = 3'd6;
  localparam logic [31:0] C_START = 32'h1, C_STOP = 32'h2, C_PAUSE = 32'h4,
                          C_RSTRT = 32'h8, CLR_ERR = 32'h100, CLR_BUSY = 32'h200;
  localparam logic [31:0] SETMODE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        done_i = 1'b0;
  logic        launch_o, abort_o, hold_o, resume_o, acc_prot_o;
  logic [1:0]  launch_mode_o;
  logic [31:0] launch_ptr_o, launch_len_o;
  logic [63:0] launch_fill_o;
  logic [2:0]  src_burst_o, dst_burst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  copy_chan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done_i(done_i), .launch_o(launch_o),
    .launch_mode_o(launch_mode_o), .launch_ptr_o(launch_ptr_o), .launch_len_o(launch_len_o),
    .launch_fill_o(launch_fill_o), .abort_o(abort_o), .hold_o(hold_o), .resume_o(resume_o),
    .src_burst_o(src_burst_o), .dst_burst_o(dst_burst_o), .acc_prot_o(acc_prot_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // Command write, then wait until the state update is visible.
  task automatic issue(input logic [31:0] c);
    wr(A_ACT, c);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic status_is(input string req, input logic [1:0] exp);
    logic [31:0] v;
    rd(A_ACT, v);
    check(req, 64'(v[5:4]), 64'(exp));
  endtask

  task automatic flags_are(input string req, input logic err, input logic busy);
    logic [31:0] v;
    rd(A_ACT, v);
    check(req, 64'({v[9], v[8]}), 64'({busy, err}));
  endtask

  task automatic pulse_done();
    @(negedge clk); done_i = 1'b1;
    @(negedge clk); done_i = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    wr(A_CFG, SETMODE | 32'h0000_0440 | 32'h1000 | 32'(m));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    status_is("R1 status", 2'b00);
    flags_are("R1 flags", 1'b0, 1'b0);
    rd(A_CFG, v);
    check("R1 cfg", 64'(v[12:0]), 64'h1440);
    check("R1 pulses", 64'({launch_o, abort_o, hold_o, resume_o}), 64'h0);
  endtask

  task automatic t_xor_start();
    logic [31:0] v;
    set_mode(2'd0);
    wr(A_NDP, 32'h1000_0040);
    wr(A_ACT, C_START);
    rd(A_ACT, v);
    check("R13 cmd visible", 64'(v[3:0]), 64'h1);
    @(negedge clk);
    check("R2 launch", 64'(launch_o), 64'h1);
    check("R2 mode", 64'(launch_mode_o), 64'h0);
    check("R2 ptr", 64'(launch_ptr_o), 64'h1000_0040);
    status_is("R2 status", 2'b01);
    rd(A_ACT, v);
    check("R13 cmd cleared", 64'(v[3:0]), 64'h0);
    @(negedge clk);
    check("R2 single launch", 64'(launch_o), 64'h0);
    pulse_done();
    status_is("R12 done to idle", 2'b00);
  endtask

  task automatic t_xor_align();
    wr(A_NDP, 32'h1000_0020);
    issue(C_START);
    check("R3 no launch bit5", 64'(launch_o), 64'h0);
    status_is("R3 stays idle", 2'b00);
    flags_are("R3 error bit5", 1'b1, 1'b0);
    wr(A_ACT, CLR_ERR);
    flags_are("R10 err cleared", 1'b0, 1'b0);
    wr(A_NDP, 32'h0);
    issue(C_START);
    flags_are("R3 error null", 1'b1, 1'b0);
    wr(A_ACT, CLR_ERR);
  endtask

  task automatic t_copy_crc();
    set_mode(2'd1);
    wr(A_NDP, 32'h0000_0020);
    issue(C_START);
    check("R4 dma launch", 64'(launch_o), 64'h1);
    check("R4 dma mode", 64'(launch_mode_o), 64'h1);
    pulse_done();
    wr(A_NDP, 32'h0000_0028);
    issue(C_START);
    check("R4 dma misaligned no launch", 64'(launch_o), 64'h0);
    flags_are("R4 dma misaligned error", 1'b1, 1'b0);
    wr(A_ACT, CLR_ERR);
    set_mode(2'd2);
    wr(A_NDP, 32'h0000_0060);
    issue(C_START);
    check("R4 crc launch", 64'(launch_o), 64'h1);
    check("R4 crc mode", 64'(launch_mode_o), 64'h2);
    pulse_done();
  endtask

  task automatic t_fill();
    set_mode(2'd3);
    wr(A_DST, 32'h0000_2000);
    wr(A_FLO, 32'h1234_5678);
    wr(A_FHI, 32'hAAAA_5555);
    wr(A_NDP, 32'h0000_0003);
    wr(A_BSZ, 32'd128);
    issue(C_START);
    check("R5 fill launch", 64'(launch_o), 64'h1);
    check("R5 fill ptr", 64'(launch_ptr_o), 64'h2000);
    check("R5 fill len", 64'(launch_len_o), 64'd128);
    check("R5 fill pattern", launch_fill_o, 64'hAAAA_5555_1234_5678);
    pulse_done();
    wr(A_BSZ, 32'd127);
    issue(C_START);
    check("R5 below min", 64'(launch_o), 64'h0);
    flags_are("R5 below min error", 1'b1, 1'b0);
    wr(A_ACT, CLR_ERR);
    wr(A_BSZ, 32'h0100_0000);
    issue(C_START);
    check("R5 above max", 64'(launch_o), 64'h0);
    flags_are("R5 above max error", 1'b1, 1'b0);
    wr(A_ACT, CLR_ERR);
    wr(A_BSZ, 32'h00FF_FFFF);
    issue(C_START);
    check("R5 at max", 64'(launch_o), 64'h1);
    pulse_done();
  endtask

  task automatic start_xor_job();
    set_mode(2'd0);
    wr(A_NDP, 32'h0000_0080);
    issue(C_START);
  endtask

  task automatic t_busy();
    start_xor_job();
    issue(C_START);
    check("R6 no second launch", 64'(launch_o), 64'h0);
    status_is("R6 still active", 2'b01);
    flags_are("R6 busy only", 1'b0, 1'b1);
    wr(A_ACT, CLR_BUSY);
    flags_are("R10 busy cleared", 1'b0, 1'b0);
    pulse_done();
  endtask

  task automatic t_pause_restart();
    start_xor_job();
    issue(C_PAUSE);
    check("R7 hold pulse", 64'(hold_o), 64'h1);
    status_is("R7 paused", 2'b10);
    pulse_done();
    status_is("R12 done ignored paused", 2'b10);
    issue(C_RSTRT);
    check("R7 resume pulse", 64'(resume_o), 64'h1);
    status_is("R7 restarted", 2'b01);
    issue(C_PAUSE);
    issue(C_START);
    check("R7 start from paused", 64'(launch_o), 64'h1);
    status_is("R7 active again", 2'b01);
    pulse_done();
    pulse_done();
    status_is("R12 done ignored idle", 2'b00);
  endtask

  task automatic t_stop();
    start_xor_job();
    issue(C_STOP);
    check("R8 abort pulse", 64'(abort_o), 64'h1);
    status_is("R8 stopped", 2'b00);
    issue(C_STOP);
    check("R8 idle stop no abort", 64'(abort_o), 64'h0);
    flags_are("R8 idle stop no error", 1'b0, 1'b0);
    status_is("R8 idle stop stays idle", 2'b00);
  endtask

  task automatic t_illegal();
    issue(C_PAUSE);
    status_is("R9 pause idle stays", 2'b00);
    flags_are("R9 pause idle error", 1'b1, 1'b0);
    wr(A_ACT, 32'h0);
    flags_are("R10 write zero keeps", 1'b1, 1'b0);
    wr(A_ACT, CLR_ERR);
    issue(C_RSTRT);
    flags_are("R9 restart idle error", 1'b1, 1'b0);
    wr(A_ACT, CLR_ERR);
    start_xor_job();
    issue(C_STOP | C_PAUSE);
    status_is("R9 multi bit stays active", 2'b01);
    flags_are("R9 multi bit error", 1'b1, 1'b0);
    wr(A_ACT, CLR_ERR);
    issue(C_PAUSE);
    issue(C_STOP);
    status_is("R9 stop paused stays", 2'b10);
    flags_are("R9 stop paused error", 1'b1, 1'b0);
    wr(A_ACT, CLR_ERR);
    issue(C_RSTRT);
    issue(C_STOP);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    set_mode(2'd1);
    wr(A_CFG, 32'h0000_0562);
    rd(A_CFG, v);
    check("R11 mode kept", 64'(v[1:0]), 64'h1);
    check("R11 bursts", 64'({src_burst_o, dst_burst_o, acc_prot_o}), 64'({3'd6, 3'd5, 1'b0}));
    wr(A_CFG, SETMODE | 32'h0000_0002);
    rd(A_CFG, v);
    check("R11 mode loaded", 64'(v[1:0]), 64'h2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_xor_start();
    t_xor_align();
    t_copy_crc();
    t_fill();
    t_busy();
    t_pause_restart();
    t_stop();
    t_illegal();
    t_cfg();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule